// File: doc/BRIEF.md
# Locked Bus Cycle Sequencer

This block is a bus master that turns one request into one or two memory or IO bus cycles and marks the cycles that must run atomically with an active-low lock line. A request names one of four operations: a plain read, a plain write, a read-modify-write pair, or an interrupt-acknowledge pair of reads. For each bus cycle it drives a one-clock address strobe together with the address, the direction and the memory/IO select. It then waits for an active-low ready from the system.

For a read-modify-write, a fixed modify interval separates the read from the write. The write goes to the same address and carries the read value plus one. The interrupt-acknowledge pair runs its two reads with only the mandatory idle clock between them. Lock is applied only when the pair targets memory. Every bus cycle is followed by at least one clock without a strobe. The lock line always returns high for at least one clock between two atomic groups.

Top module: `locked_bus_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request presented with `req_valid` high in such a clock is taken at that edge, and `req_ready` is low in the following clock. Operation codes on `req_op` are 0 read, 1 write, 2 read-modify-write, 3 interrupt-acknowledge pair.
- R2: Each bus cycle asserts `bus_ads_n` low for exactly one clock. In that clock `bus_addr` holds the requested address, `bus_wr` is 1 for a write and 0 for a read, and `bus_mio` is 1 for memory (`req_io`=0) and 0 for IO.
- R3: A cycle ends at the first clock after its strobe in which `bus_rdy_n` is sampled low, after any number of wait clocks.
- R4: Between the end of one bus cycle and the next strobe there is at least one clock with `bus_ads_n` high.
- R5: For a memory read-modify-write or interrupt-acknowledge pair, `bus_lock_n` goes low in the same clock as the first strobe. Plain reads and writes leave it high.
- R6: `bus_lock_n` stays low through the clock in which the last ready of the group is sampled and is high in the following clock, so it is negated for at least one clock between back-to-back locked groups.
- R7: A read-modify-write is a read and then a write to the same address. The write strobe comes MOD_CLKS+1 clocks after the clock of the read's ready, and its `bus_wdata` equals the read data plus one.
- R8: An interrupt-acknowledge pair is two reads. The second strobe comes 2 clocks after the clock of the first read's ready.
- R9: A request with `req_io`=1 never asserts `bus_lock_n`, even for a paired operation.
- R10: `done` pulses for one clock, in the clock after the final ready of an operation. For operations that read, `done_rdata` then holds the data of the last read.
- R11: After reset the strobe and lock are high, `done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | Operation code (see R1) |
| req_io | input | 1 | 1 selects IO space |
| req_addr | input | AW | Target address |
| req_wdata | input | DW | Write data for a plain write |
| bus_ads_n | output | 1 | Address strobe, active low |
| bus_addr | output | AW | Bus address |
| bus_wr | output | 1 | 1 write, 0 read |
| bus_mio | output | 1 | 1 memory, 0 IO |
| bus_lock_n | output | 1 | Atomic-group indication, active low |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, taken with ready |
| bus_rdy_n | input | 1 | Cycle ready, active low |
| done | output | 1 | Operation complete pulse |
| done_rdata | output | DW | Last read data |

## Verification
The release of lock at the end of one atomic group and the start of the next locked request can meet in adjacent clocks. The bench presents a new locked request in the very clock where `done` is first seen. It then checks that `bus_lock_n` is high in that clock and falls again exactly with the next strobe. The bus responder varies the number of wait clocks on each cycle. A queue of expected cycles checks every strobe for address, direction, space, lock level, write data and spacing from the previous ready.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2,
    OP_IACK  = 2'd3
  } lbs_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_SPACE,
    ST_MOD
  } lbs_state_e;
endpackage

// File: rtl/lbs_rst_sync.sv
module lbs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/lbs_mod_timer.sv
module lbs_mod_timer #(
  parameter int unsigned MOD_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic tmr_last
);
  localparam int unsigned CW = (MOD_CLKS < 2) ? 1 : $clog2(MOD_CLKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load | run;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                 cnt_d = CW'(MOD_CLKS);
    else if (run && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign tmr_last = (cnt_q == CW'(1));

  // R7: the modify interval never runs with an exhausted count
  p_mod_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q != '0));
endmodule

// File: rtl/lbs_bus_regs.sv
module lbs_bus_regs
  import lbs_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  lbs_op_e       req_op,
  input  logic          req_io,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          rd_done,
  input  logic [DW-1:0] bus_rdata,
  output lbs_op_e       op_q,
  output logic          io_q,
  output logic          locked_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  logic          req_pair;
  logic          wdata_en;
  logic [DW-1:0] wdata_d;

  assign req_pair = (req_op == OP_RMW) || (req_op == OP_IACK);
  assign wdata_en = accept | (rd_done && op_q == OP_RMW);

  always_comb begin
    wdata_d = wdata_q;
    if (accept)       wdata_d = req_wdata;
    else if (rd_done) wdata_d = bus_rdata + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_READ;
      io_q     <= 1'b0;
      locked_q <= 1'b0;
      addr_q   <= '0;
    end else if (accept) begin
      op_q     <= req_op;
      io_q     <= req_io;
      locked_q <= req_pair && !req_io;
      addr_q   <= req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wdata_q <= '0;
    else if (wdata_en) wdata_q <= wdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_done) rdata_q <= bus_rdata;
  end

  // R7: write data of the pair is the read value incremented
  p_rmw_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && op_q == OP_RMW) |=> (wdata_q == $past(bus_rdata) + DW'(1)));
  // R2: address is stable during an operation
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(addr_q));
endmodule

// File: rtl/lbs_fsm.sv
module lbs_fsm
  import lbs_pkg::*;
#(
  parameter int unsigned MOD_CLKS = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  lbs_op_e op_q,
  input  logic    locked_q,
  input  logic    bus_rdy_n,
  output logic    req_ready,
  output logic    accept,
  output logic    rd_done,
  output logic    ads_n,
  output logic    lock_n,
  output logic    is_write,
  output logic    done
);
  lbs_state_e state_q, state_d;
  logic       second_q, second_d;
  logic       pair, cyc_end, final_end;
  logic       tmr_load, tmr_run, tmr_last;

  assign pair      = (op_q == OP_RMW) || (op_q == OP_IACK);
  assign is_write  = (op_q == OP_WRITE) || (op_q == OP_RMW && second_q);
  assign cyc_end   = (state_q == ST_WAIT) && !bus_rdy_n;
  assign final_end = cyc_end && (!pair || second_q);
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign rd_done   = cyc_end && !is_write;
  assign tmr_load  = cyc_end && !final_end && (op_q == OP_RMW);
  assign tmr_run   = (state_q == ST_MOD);

  lbs_mod_timer #(.MOD_CLKS(MOD_CLKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .run      (tmr_run),
    .tmr_last (tmr_last)
  );

  always_comb begin
    state_d  = state_q;
    second_d = second_q;
    case (state_q)
      ST_IDLE: if (accept) begin
        state_d  = ST_ADDR;
        second_d = 1'b0;
      end
      ST_ADDR:  state_d = ST_WAIT;
      ST_WAIT: if (cyc_end) begin
        if (final_end) begin
          state_d = ST_IDLE;
        end else begin
          second_d = 1'b1;
          state_d  = (op_q == OP_RMW) ? ST_MOD : ST_SPACE;
        end
      end
      ST_SPACE: state_d = ST_ADDR;
      ST_MOD:   if (tmr_last) state_d = ST_ADDR;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      second_q <= 1'b0;
      done     <= 1'b0;
    end else begin
      state_q  <= state_d;
      second_q <= second_d;
      done     <= final_end;
    end
  end

  assign ads_n  = (state_q != ST_ADDR);
  assign lock_n = !(locked_q && state_q != ST_IDLE);

  // R1: idle handshake never coincides with bus activity
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ads_n && lock_n));
  // R2: strobe lasts a single clock
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |=> ads_n);
  // R4: the clock after a ready has no strobe
  p_idle_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> ads_n);
  // R5: lock only falls together with a strobe
  p_lock_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n) |-> !ads_n);
  // R6: lock only rises right after a sampled ready
  p_lock_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_n) |-> $past(!bus_rdy_n));
  // R8: spacing clock of the acknowledge pair leads into a strobe
  p_iack_space_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SPACE) |=> !ads_n);
  // R10: done follows a ready
  p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!bus_rdy_n));
endmodule

// File: rtl/locked_bus_seq.sv
module locked_bus_seq
  import lbs_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned MOD_CLKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic          req_io,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          bus_ads_n,
  output logic [AW-1:0] bus_addr,
  output logic          bus_wr,
  output logic          bus_mio,
  output logic          bus_lock_n,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rdy_n,
  output logic          done,
  output logic [DW-1:0] done_rdata
);
  logic    rst_n_s;
  logic    accept, rd_done;
  logic    io_q, locked_q;
  lbs_op_e op_q;

  lbs_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  lbs_fsm #(.MOD_CLKS(MOD_CLKS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req_valid (req_valid),
    .op_q      (op_q),
    .locked_q  (locked_q),
    .bus_rdy_n (bus_rdy_n),
    .req_ready (req_ready),
    .accept    (accept),
    .rd_done   (rd_done),
    .ads_n     (bus_ads_n),
    .lock_n    (bus_lock_n),
    .is_write  (bus_wr),
    .done      (done)
  );

  lbs_bus_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .accept    (accept),
    .req_op    (lbs_op_e'(req_op)),
    .req_io    (req_io),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_done   (rd_done),
    .bus_rdata (bus_rdata),
    .op_q      (op_q),
    .io_q      (io_q),
    .locked_q  (locked_q),
    .addr_q    (bus_addr),
    .wdata_q   (bus_wdata),
    .rdata_q   (done_rdata)
  );

  assign bus_mio = !io_q;

  // R9: IO space never carries lock
  p_io_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bus_mio |-> bus_lock_n);
endmodule

// File: tb/sim_locked_bus_seq.sv
`timescale 1ns/1ps
module sim_locked_bus_seq;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int MODC = 2;

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic        mio;
    logic        lock_n;
    logic [31:0] wdata;
    logic [31:0] rdval;
    logic [7:0]  waitc;
    logic [7:0]  gap;
    logic        last;
    logic        chk_data;
    logic [31:0] done_data;
  } cyc_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = 2'd0;
  logic req_io = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic bus_ads_n, bus_wr, bus_mio, bus_lock_n, done;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, done_rdata;
  logic [DW-1:0] bus_rdata = '0;
  logic bus_rdy_n = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  cyc_t exp_q[$];

  always #4 clk = ~clk;

  locked_bus_seq #(.AW(AW), .DW(DW), .MOD_CLKS(MODC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_ads_n(bus_ads_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_mio(bus_mio),
    .bus_lock_n(bus_lock_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdy_n(bus_rdy_n), .done(done), .done_rdata(done_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor and bus responder
  int   neg_idx = 0;
  int   last_rdy = -1000;
  bit   in_cyc = 1'b0;
  bit   pend = 1'b0;
  int   wait_left = 0;
  cyc_t cur;

  always @(negedge clk) begin
    neg_idx++;
    if (rst_n) begin
      if (pend) begin
        pend = 1'b0;
        chk(bus_lock_n == (cur.last ? 1'b1 : cur.lock_n), "R6 lock after ready",
            64'(bus_lock_n), 64'(cur.last ? 1'b1 : cur.lock_n));
        chk(done == cur.last, "R10 done pulse", 64'(done), 64'(cur.last));
        if (cur.last && cur.chk_data)
          chk(done_rdata == cur.done_data, "R10 done data", 64'(done_rdata),
              64'(cur.done_data));
      end
      if (!bus_ads_n) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected strobe", 64'(bus_addr), 64'(0));
        end else begin
          cur = exp_q.pop_front();
          chk(bus_addr == cur.addr, "R2 address", 64'(bus_addr), 64'(cur.addr));
          chk(bus_wr == cur.wr, "R2 direction", 64'(bus_wr), 64'(cur.wr));
          chk(bus_mio == cur.mio, "R2 space", 64'(bus_mio), 64'(cur.mio));
          chk(bus_lock_n == cur.lock_n, "R5 R9 lock at strobe", 64'(bus_lock_n),
              64'(cur.lock_n));
          if (cur.wr)
            chk(bus_wdata == cur.wdata, "R7 write data", 64'(bus_wdata), 64'(cur.wdata));
          if (cur.gap != 0)
            chk((neg_idx - last_rdy) == int'(cur.gap), "R7 R8 pair spacing",
                64'(neg_idx - last_rdy), 64'(cur.gap));
          else
            chk((neg_idx - last_rdy) >= 2, "R4 idle clock", 64'(neg_idx - last_rdy), 64'(2));
        end
        in_cyc    = 1'b1;
        wait_left = int'(cur.waitc);
        bus_rdy_n = 1'b1;
      end else if (in_cyc) begin
        if (!cur.lock_n)
          chk(bus_lock_n == 1'b0, "R6 lock held", 64'(bus_lock_n), 64'(0));
        if (wait_left == 0) begin
          bus_rdy_n = 1'b0;
          bus_rdata = cur.rdval;
          in_cyc    = 1'b0;
          pend      = 1'b1;
          last_rdy  = neg_idx;
        end else begin
          wait_left--;
          bus_rdy_n = 1'b1;
        end
      end else begin
        bus_rdy_n = 1'b1;
      end
    end
  end

  function automatic cyc_t mk(input logic [31:0] a, input logic w, input logic m,
                              input logic l, input logic [31:0] wd, input logic [31:0] rv,
                              input logic [7:0] wt, input logic [7:0] g, input logic ls,
                              input logic cd, input logic [31:0] dd);
    cyc_t c;
    c.addr = a; c.wr = w; c.mio = m; c.lock_n = l; c.wdata = wd; c.rdval = rv;
    c.waitc = wt; c.gap = g; c.last = ls; c.chk_data = cd; c.done_data = dd;
    return c;
  endfunction

  // Driver: queue expectations, then run the handshake
  task automatic do_op(input logic [1:0] op, input logic io, input logic [31:0] a,
                       input logic [31:0] wd, input logic [31:0] r0, input logic [31:0] r1,
                       input logic [7:0] w0, input logic [7:0] w1);
    logic lk;
    lk = !((op == 2'd2 || op == 2'd3) && !io);
    case (op)
      2'd0: exp_q.push_back(mk(a, 1'b0, !io, 1'b1, '0, r0, w0, 8'd0, 1'b1, 1'b1, r0));
      2'd1: exp_q.push_back(mk(a, 1'b1, !io, 1'b1, wd, r0, w0, 8'd0, 1'b1, 1'b0, '0));
      2'd2: begin
        exp_q.push_back(mk(a, 1'b0, !io, lk, '0, r0, w0, 8'd0, 1'b0, 1'b0, '0));
        exp_q.push_back(mk(a, 1'b1, !io, lk, r0 + 1, r1, w1, 8'(MODC + 1), 1'b1, 1'b1, r0));
      end
      default: begin
        exp_q.push_back(mk(a, 1'b0, !io, lk, '0, r0, w0, 8'd0, 1'b0, 1'b0, '0));
        exp_q.push_back(mk(a, 1'b0, !io, lk, '0, r1, w1, 8'd2, 1'b1, 1'b1, r1));
      end
    endcase
    while (!req_ready) @(negedge clk);
    req_op = op; req_io = io; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 busy after accept", 64'(req_ready), 64'(0));
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bus_ads_n == 1'b1, "R11 strobe idle", 64'(bus_ads_n), 64'(1));
    chk(bus_lock_n == 1'b1, "R11 lock idle", 64'(bus_lock_n), 64'(1));
    chk(done == 1'b0, "R11 done low", 64'(done), 64'(0));
    chk(req_ready == 1'b1, "R11 R1 ready", 64'(req_ready), 64'(1));
    do_op(2'd0, 1'b0, 32'h0000_1000, '0, 32'hA5A5_0001, '0, 8'd0, 8'd0);           // R3 no wait
    do_op(2'd1, 1'b0, 32'h0000_2004, 32'hDEAD_BEEF, '0, '0, 8'd3, 8'd0);         // R3 waits
    do_op(2'd2, 1'b0, 32'h0000_3008, '0, 32'h0000_00FF, '0, 8'd1, 8'd2);         // R7
    do_op(2'd2, 1'b0, 32'h0000_300C, '0, 32'hFFFF_FFFF, '0, 8'd0, 8'd0);         // R6 back-to-back
    do_op(2'd3, 1'b0, 32'h0000_0000, '0, 32'h0000_0020, 32'h0000_0021, 8'd2, 8'd0); // R8
    do_op(2'd2, 1'b1, 32'h0000_0080, '0, 32'h1234_5678, '0, 8'd0, 8'd1);         // R9 IO pair
    do_op(2'd0, 1'b1, 32'h0000_0084, '0, 32'h0BAD_F00D, '0, 8'd1, 8'd0);         // R9 IO read
    do_op(2'd3, 1'b0, 32'h0000_0010, '0, 32'h0000_0030, 32'h0000_0031, 8'd0, 8'd4); // R5 R6
    repeat (3) @(negedge clk);
    chk(bus_lock_n == 1'b1 && done == 1'b0, "R6 R10 quiet at end",
        64'({bus_lock_n, done}), 64'(2));
    chk(exp_q.size() == 0, "R2 all cycles seen", 64'(exp_q.size()), 64'(0));
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule